// File: doc/BRIEF.md
# Debug Firmware Command Executor

This block runs on the target side of a background debug link. It takes opcodes that have already been received and executes them. Each opcode arrives as a one-cycle strobe with an 8-bit code. Some commands also need a 16-bit data word, which arrives later as a separate one-cycle strobe. The commands act on a small register file holding the program counter, the D accumulator, the X and Y index registers and the stack pointer. Two commands step X forward by one word and then access memory at the new X through a simple request/wait memory port. While such an access is stalled, the block raises a freeze signal that holds the processor clock.

Read commands place their result in a 16-bit holding register and mark it with a one-cycle response strobe. Three exit commands leave debug mode after a fixed-length exit sequence. During that sequence the holding register serves as scratch and its contents have no meaning. The three exit commands are plain resume, single step and resume with tagging enabled. Each raises its own one-cycle strobe. After a single step the block returns to debug mode when the step is reported complete. After the other two it returns when an external debug-entry request arrives.

Top module: `dbg_cmd_exec`

## Requirements
- R1: After reset, `dbg_active` is 1. `rsp_valid`, `mem_req`, `freeze`, `tag_en` and all three exit strobes are 0. All five registers read back as 0.
- R2: Register reads use opcodes 0x63, 0x64, 0x65, 0x66 and 0x67, which select PC, D, X, Y and SP in that order. On the clock edge that samples the opcode, the selected register is copied into `shift_q` and `rsp_valid` rises for one cycle.
- R3: Register writes use opcodes 0x43 to 0x47, in the same register order as R2. After one of these opcodes, the next `data_valid` word is written into the selected register. Opcodes that arrive while the data word is awaited are ignored. A `data_valid` that arrives with no write pending changes nothing.
- R4: Opcode 0x62 adds 2 to X, wrapping modulo 2^16, and reads the word at the new X. The edge that completes the access loads the word into `shift_q` and pulses `rsp_valid`.
- R5: Opcode 0x42 waits for a data word. It then adds 2 to X, wrapping modulo 2^16, and writes that word to memory at the new X, with `mem_we` high.
- R6: An access starts on the edge that samples its opcode or data word, so `mem_req` is visible in the following cycle. `mem_addr`, `mem_we` and `mem_wdata` hold steady while `mem_wait` is high. The access completes in the first cycle with `mem_req` high and `mem_wait` low, and `mem_req` drops after that cycle.
- R7: `freeze` is high in every cycle of an access after its first one, up to and including the completing cycle. It is low at all other times. An access with no wait cycles therefore never freezes.
- R8: Opcode 0x08 starts an exit sequence. `go_pulse` is high for one cycle, visible after the EXIT_LEN-th edge following the opcode edge, and `dbg_active` falls at that same edge. Opcodes are ignored during the exit sequence and while the user program runs. `enter_dbg` returns the block to debug mode.
- R9: Opcode 0x10 runs the same exit sequence but ends with a one-cycle `step_pulse`. `dbg_active` stays low until `step_done` is sampled high, and is high again in the next cycle.
- R10: Opcode 0x18 runs the same exit sequence but ends with a one-cycle `tag_pulse`, and sets `tag_en` on the same edge. A later `enter_dbg` clears `tag_en` and restores `dbg_active`.
- R11: Any opcode outside 0x08, 0x10, 0x18, 0x42 to 0x47 and 0x62 to 0x67 is ignored. It changes no register, and it starts no response, access or exit.
- R12: At most one of the three exit strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle strobe for a received opcode |
| cmd_code | input | 8 | Received opcode |
| data_valid | input | 1 | One-cycle strobe for a received data word |
| data_in | input | DW | Received data word |
| enter_dbg | input | 1 | Request to return to debug mode from the running state |
| step_done | input | 1 | The single stepped instruction has finished |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Access address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid while the request is not waiting |
| mem_wait | input | 1 | Memory stalls the current access |
| freeze | output | 1 | Processor clock hold during a stalled access |
| shift_q | output | DW | Response holding register |
| rsp_valid | output | 1 | One-cycle strobe: `shift_q` holds a fresh result |
| go_pulse | output | 1 | Resume strobe |
| step_pulse | output | 1 | Single-step strobe |
| tag_pulse | output | 1 | Tagged-resume strobe |
| tag_en | output | 1 | Tagging enabled |
| dbg_active | output | 1 | Block is in debug mode |

## Verification
The assertions assume that the memory raises `mem_wait` only while `mem_req` is high. They also assume it returns valid `mem_rdata` in the cycle where it lets an access finish. The bench memory model derives `mem_wait` from `mem_req` and a per-test wait count, so this holds by construction. The opcode and data strobes are assumed to be single-cycle and not to overlap. The bench drives each one for exactly one cycle, away from the clock edge. `step_done` and `enter_dbg` are raised only after the matching exit strobe has been seen, so every exit completes before the block is asked to return.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

  // opcodes whose values the decoder depends on
  localparam logic [7:0] OP_GO    = 8'h08;
  localparam logic [7:0] OP_STEP  = 8'h10;
  localparam logic [7:0] OP_TAG   = 8'h18;
  localparam logic [4:0] RD_GROUP = 5'b01100;
  localparam logic [4:0] WR_GROUP = 5'b01000;

  typedef enum logic [2:0] {
    SEL_NEXT = 3'd2,
    SEL_PC   = 3'd3,
    SEL_D    = 3'd4,
    SEL_X    = 3'd5,
    SEL_Y    = 3'd6,
    SEL_SP   = 3'd7
  } reg_sel_e;

  typedef enum logic [2:0] {
    K_NONE,
    K_RD_REG,
    K_RD_MEM,
    K_WR_REG,
    K_WR_MEM,
    K_GO,
    K_STEP,
    K_TAG
  } cmd_kind_e;

  typedef struct packed {
    cmd_kind_e kind;
    reg_sel_e  sel;
  } dec_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WDATA,
    ST_MEM,
    ST_EXIT,
    ST_RUN,
    ST_STEP
  } state_e;

  localparam int NREG  = 5;
  localparam int X_IDX = 2;

  function automatic logic [2:0] sel_index(input reg_sel_e s);
    return 3'(s) - 3'd3;
  endfunction

endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
  import dbg_pkg::*;
(
  input  logic [7:0] code,
  output dec_t       dec
);

  logic low_ok;
  assign low_ok = (code[2:1] != 2'b00);

  always_comb begin
    dec = '{kind: K_NONE, sel: SEL_PC};
    if (code[7:3] == RD_GROUP && low_ok) begin
      dec.sel  = reg_sel_e'(code[2:0]);
      dec.kind = (code[2:0] == 3'd2) ? K_RD_MEM : K_RD_REG;
    end else if (code[7:3] == WR_GROUP && low_ok) begin
      dec.sel  = reg_sel_e'(code[2:0]);
      dec.kind = (code[2:0] == 3'd2) ? K_WR_MEM : K_WR_REG;
    end else if (code == OP_GO) begin
      dec.kind = K_GO;
    end else if (code == OP_STEP) begin
      dec.kind = K_STEP;
    end else if (code == OP_TAG) begin
      dec.kind = K_TAG;
    end
  end

endmodule

// File: rtl/dbg_regfile.sv
module dbg_regfile
  import dbg_pkg::*;
#(
  parameter int DW    = 16,
  parameter int XSTEP = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  reg_sel_e      wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          x_bump,
  input  reg_sel_e      rd_sel,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] x_next
);

  logic [DW-1:0] regs [NREG];
  logic [2:0]    wi;
  logic [2:0]    ri;

  assign wi     = sel_index(wr_sel);
  assign ri     = sel_index(rd_sel);
  assign x_next = regs[X_IDX] + DW'(XSTEP);

  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[gi] <= '0;
      end else if (wr_en && wi == 3'(gi)) begin
        regs[gi] <= wr_data;
      end else if (gi == X_IDX && x_bump) begin
        regs[gi] <= x_next;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++) begin
      if (ri == 3'(i)) rd_data = regs[i];
    end
  end

endmodule

// File: rtl/dbg_mem_port.sv
module dbg_mem_port #(
  parameter int DW = 16,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          we_in,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  input  logic          mem_wait,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          freeze,
  output logic          done
);

  assign done = mem_req && !mem_wait;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      freeze    <= 1'b0;
    end else if (start) begin
      mem_req   <= 1'b1;
      mem_we    <= we_in;
      mem_addr  <= addr_in;
      mem_wdata <= wdata_in;
      freeze    <= 1'b0;
    end else if (mem_req) begin
      if (mem_wait) begin
        freeze <= 1'b1;
      end else begin
        mem_req <= 1'b0;
        mem_we  <= 1'b0;
        freeze  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dbg_cmd_exec.sv
module dbg_cmd_exec
  import dbg_pkg::*;
#(
  parameter int DW       = 16,
  parameter int AW       = 16,
  parameter int EXIT_LEN = 64,
  parameter int XSTEP    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [7:0]    cmd_code,
  input  logic          data_valid,
  input  logic [DW-1:0] data_in,
  input  logic          enter_dbg,
  input  logic          step_done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_wait,
  output logic          freeze,
  output logic [DW-1:0] shift_q,
  output logic          rsp_valid,
  output logic          go_pulse,
  output logic          step_pulse,
  output logic          tag_pulse,
  output logic          tag_en,
  output logic          dbg_active
);

  localparam int CW = $clog2(EXIT_LEN + 1);
  localparam logic [CW-1:0] ECNT_LAST = CW'(EXIT_LEN - 1);

  state_e        st;
  dec_t          dec;
  dec_t          pend;
  logic [CW-1:0] ecnt;

  logic          rf_we;
  logic          rf_bump;
  logic [DW-1:0] rf_rdata;
  logic [DW-1:0] rf_xnext;
  logic          mp_we;
  logic          mp_done;
  logic          cmd_go;
  logic          dat_go;

  dbg_cmd_decode u_dec (
    .code (cmd_code),
    .dec  (dec)
  );

  assign cmd_go  = (st == ST_IDLE) && cmd_valid;
  assign dat_go  = (st == ST_WDATA) && data_valid;
  assign rf_we   = dat_go && (pend.kind == K_WR_REG);
  assign rf_bump = (cmd_go && dec.kind == K_RD_MEM) ||
                   (dat_go && pend.kind == K_WR_MEM);
  assign mp_we   = (st == ST_WDATA);

  dbg_regfile #(
    .DW    (DW),
    .XSTEP (XSTEP)
  ) u_rf (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (rf_we),
    .wr_sel  (pend.sel),
    .wr_data (data_in),
    .x_bump  (rf_bump),
    .rd_sel  (dec.sel),
    .rd_data (rf_rdata),
    .x_next  (rf_xnext)
  );

  dbg_mem_port #(
    .DW (DW),
    .AW (AW)
  ) u_mp (
    .clk       (clk),
    .rst       (rst),
    .start     (rf_bump),
    .we_in     (mp_we),
    .addr_in   (AW'(rf_xnext)),
    .wdata_in  (data_in),
    .mem_wait  (mem_wait),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .freeze    (freeze),
    .done      (mp_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      pend       <= '{kind: K_NONE, sel: SEL_PC};
      ecnt       <= '0;
      shift_q    <= '0;
      rsp_valid  <= 1'b0;
      go_pulse   <= 1'b0;
      step_pulse <= 1'b0;
      tag_pulse  <= 1'b0;
      tag_en     <= 1'b0;
      dbg_active <= 1'b1;
    end else begin
      rsp_valid  <= 1'b0;
      go_pulse   <= 1'b0;
      step_pulse <= 1'b0;
      tag_pulse  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (cmd_valid) begin
            case (dec.kind)
              K_RD_REG: begin
                shift_q   <= rf_rdata;
                rsp_valid <= 1'b1;
              end
              K_RD_MEM: begin
                pend <= dec;
                st   <= ST_MEM;
              end
              K_WR_REG, K_WR_MEM: begin
                pend <= dec;
                st   <= ST_WDATA;
              end
              K_GO, K_STEP, K_TAG: begin
                pend <= dec;
                ecnt <= '0;
                st   <= ST_EXIT;
              end
              default: ;
            endcase
          end
        end
        ST_WDATA: begin
          if (data_valid) begin
            st <= (pend.kind == K_WR_MEM) ? ST_MEM : ST_IDLE;
          end
        end
        ST_MEM: begin
          if (mp_done) begin
            st <= ST_IDLE;
            if (pend.kind == K_RD_MEM) begin
              shift_q   <= mem_rdata;
              rsp_valid <= 1'b1;
            end
          end
        end
        ST_EXIT: begin
          // holding register is scratch while leaving debug mode
          shift_q <= {shift_q[DW-2:0], shift_q[DW-1]};
          if (ecnt == ECNT_LAST) begin
            dbg_active <= 1'b0;
            case (pend.kind)
              K_STEP: begin
                step_pulse <= 1'b1;
                st         <= ST_STEP;
              end
              K_TAG: begin
                tag_pulse <= 1'b1;
                tag_en    <= 1'b1;
                st        <= ST_RUN;
              end
              default: begin
                go_pulse <= 1'b1;
                st       <= ST_RUN;
              end
            endcase
          end else begin
            ecnt <= ecnt + 1'b1;
          end
        end
        ST_RUN: begin
          if (enter_dbg) begin
            dbg_active <= 1'b1;
            tag_en     <= 1'b0;
            st         <= ST_IDLE;
          end
        end
        ST_STEP: begin
          if (step_done) begin
            dbg_active <= 1'b1;
            st         <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dbg_cmd_exec_chk.sv
module dbg_cmd_exec_chk #(
  parameter int DW = 16,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_wait,
  input logic          freeze,
  input logic          go_pulse,
  input logic          step_pulse,
  input logic          tag_pulse,
  input logic          tag_en,
  input logic          dbg_active
);

  // R7
  freeze_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    freeze |-> mem_req);

  // R7
  freeze_after_wait_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(freeze) |-> $past(mem_req && mem_wait));

  // R6
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_wait) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R6
  mem_release_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_wait) |=> !mem_req);

  // R8
  mem_in_debug_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> dbg_active);

  // R8
  leave_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dbg_active) |-> (go_pulse || step_pulse || tag_pulse));

  // R10
  tag_sets_en_chk: assert property (@(posedge clk) disable iff (rst)
    tag_pulse |-> tag_en);

  // R12
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({go_pulse, step_pulse, tag_pulse}));

endmodule

bind dbg_cmd_exec dbg_cmd_exec_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_wait   (mem_wait),
  .freeze     (freeze),
  .go_pulse   (go_pulse),
  .step_pulse (step_pulse),
  .tag_pulse  (tag_pulse),
  .tag_en     (tag_en),
  .dbg_active (dbg_active)
);

// File: tb/tb_dbg_cmd_exec.sv
module tb_dbg_cmd_exec;

  localparam int DW = 16;
  localparam int AW = 16;
  localparam int EXIT_LEN = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [7:0]    cmd_code = 8'h00;
  logic          data_valid = 1'b0;
  logic [DW-1:0] data_in = '0;
  logic          enter_dbg = 1'b0;
  logic          step_done = 1'b0;
  logic          mem_req, mem_we, mem_wait, freeze;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, shift_q;
  logic          rsp_valid, go_pulse, step_pulse, tag_pulse, tag_en, dbg_active;

  int nchk = 0;
  int nfail = 0;
  bit done_flag = 0;
  int wait_n = 0;
  int wcnt;
  logic [DW-1:0] bmem [0:15];
  logic [DW-1:0] m [0:4];

  always #2 clk = ~clk;

  dbg_cmd_exec #(.DW(DW), .AW(AW), .EXIT_LEN(EXIT_LEN)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .data_valid(data_valid), .data_in(data_in), .enter_dbg(enter_dbg),
    .step_done(step_done), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_wait(mem_wait), .freeze(freeze), .shift_q(shift_q),
    .rsp_valid(rsp_valid), .go_pulse(go_pulse), .step_pulse(step_pulse),
    .tag_pulse(tag_pulse), .tag_en(tag_en), .dbg_active(dbg_active)
  );

  // memory model: wait_n stall cycles per access
  assign mem_wait  = mem_req && (wcnt < wait_n);
  assign mem_rdata = bmem[mem_addr[4:1]];

  always @(posedge clk) begin
    if (rst) begin
      wcnt <= 0;
      for (int i = 0; i < 16; i++) bmem[i] <= 16'h0F00 + 16'(i);
    end else begin
      if (mem_req && mem_wait) wcnt <= wcnt + 1;
      else wcnt <= 0;
      if (mem_req && !mem_wait && mem_we) bmem[mem_addr[4:1]] <= mem_wdata;
    end
  end

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [7:0] c);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_code  = c;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic send_data(input logic [DW-1:0] d);
    @(negedge clk);
    data_valid = 1'b1;
    data_in    = d;
    @(negedge clk);
    data_valid = 1'b0;
  endtask

  task automatic rd_reg(input int r, input string tag);
    send_cmd(8'(8'h63 + r));
    check(rsp_valid === 1'b1 && shift_q === m[r], tag,
          {15'd0, rsp_valid, shift_q}, {16'd1, m[r]});
  endtask

  task automatic wr_reg(input int r, input logic [DW-1:0] v);
    send_cmd(8'(8'h43 + r));
    send_data(v);
    m[r] = v;
  endtask

  task automatic rd_all(input string tag);
    for (int r = 0; r < 5; r++) rd_reg(r, tag);
  endtask

  // R4 R6 R7: pre-incremented read with w stall cycles
  task automatic mem_read(input int w, input logic [DW-1:0] exp);
    int reqc = 0;
    int frzc = 0;
    int g = 0;
    logic [AW-1:0] a;
    wait_n = w;
    send_cmd(8'h62);
    m[2] = m[2] + 16'd2;
    a = mem_addr;
    while (!rsp_valid && g < 200) begin
      if (mem_req) reqc++;
      if (freeze) frzc++;
      @(negedge clk);
      g++;
    end
    check(a === m[2], "R4 read address", {16'd0, a}, {16'd0, m[2]});
    check(shift_q === exp && rsp_valid === 1'b1, "R4 read data",
          {16'd0, shift_q}, {16'd0, exp});
    check(reqc == w + 1, "R6 read request cycles", reqc, w + 1);
    check(frzc == w, "R7 read freeze cycles", frzc, w);
  endtask

  // R5 R6 R7: pre-incremented write with w stall cycles
  task automatic mem_write(input int w, input logic [DW-1:0] d);
    int reqc = 0;
    int frzc = 0;
    int g = 0;
    logic [AW-1:0] a;
    logic          we;
    wait_n = w;
    send_cmd(8'h42);
    check(mem_req === 1'b0, "R5 no access before data", {31'd0, mem_req}, 0);
    send_data(d);
    m[2] = m[2] + 16'd2;
    a  = mem_addr;
    we = mem_we;
    while (mem_req && g < 200) begin
      reqc++;
      if (freeze) frzc++;
      @(negedge clk);
      g++;
    end
    check(a === m[2] && we === 1'b1, "R5 write address", {15'd0, we, a}, {16'd1, m[2]});
    check(reqc == w + 1, "R6 write request cycles", reqc, w + 1);
    check(frzc == w, "R7 write freeze cycles", frzc, w);
    check(freeze === 1'b0, "R7 freeze low after access", {31'd0, freeze}, 0);
  endtask

  task automatic do_exit(input logic [7:0] c, output int lat, output bit stray);
    lat = 0;
    stray = 0;
    send_cmd(c);
    while (!(go_pulse || step_pulse || tag_pulse) && lat < 400) begin
      if (lat == 5) begin
        cmd_valid = 1'b1;
        cmd_code  = 8'h63;
      end else begin
        cmd_valid = 1'b0;
      end
      if (rsp_valid) stray = 1;
      @(negedge clk);
      lat++;
    end
    cmd_valid = 1'b0;
  endtask

  task automatic return_dbg();
    @(negedge clk);
    enter_dbg = 1'b1;
    @(negedge clk);
    enter_dbg = 1'b0;
  endtask

  function automatic bit defined_op(input int c);
    return (c == 8'h08) || (c == 8'h10) || (c == 8'h18) ||
           (c >= 8'h42 && c <= 8'h47) || (c >= 8'h62 && c <= 8'h67);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      nfail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int lat;
    bit stray;
    logic [DW-1:0] pats [4];
    for (int r = 0; r < 5; r++) m[r] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1
    check(dbg_active === 1'b1 && rsp_valid === 1'b0 && mem_req === 1'b0 &&
          freeze === 1'b0 && tag_en === 1'b0 &&
          {go_pulse, step_pulse, tag_pulse} === 3'b000,
          "R1 reset outputs", {26'd0, dbg_active, rsp_valid, mem_req, freeze, tag_en, go_pulse},
          32'h20);
    rd_all("R1 reset register value");

    // R2 R3: sweep every register with several patterns
    for (int r = 0; r < 5; r++) begin
      pats[0] = 16'h0000;
      pats[1] = 16'hFFFF;
      pats[2] = 16'hA5A5 ^ 16'(r);
      pats[3] = 16'(r * 16'h1111 + 16'h0123);
      for (int p = 0; p < 4; p++) begin
        wr_reg(r, pats[p]);
        rd_all("R2 R3 register write/read");
      end
    end

    // R3: opcode during data wait ignored; stray data ignored
    send_cmd(8'h44);
    send_cmd(8'h63);
    check(rsp_valid === 1'b0, "R3 opcode ignored while awaiting data", {31'd0, rsp_valid}, 0);
    send_data(16'h1234);
    m[1] = 16'h1234;
    rd_all("R3 write after ignored opcode");
    send_data(16'h9999);
    rd_all("R3 stray data word ignored");

    // R11: undefined opcodes
    for (int c = 0; c < 256; c++) begin
      if (!defined_op(c)) begin
        send_cmd(8'(c));
        check({rsp_valid, mem_req, go_pulse, step_pulse, tag_pulse} === 5'b0,
              "R11 undefined opcode no effect",
              {27'd0, rsp_valid, mem_req, go_pulse, step_pulse, tag_pulse}, 0);
      end
    end
    send_data(16'h7777);
    rd_all("R11 registers unchanged");

    // R4 R5 R6 R7: memory accesses with 0..3 stall cycles
    wr_reg(2, 16'h0000);
    for (int w = 0; w < 4; w++) mem_write(w, 16'h1000 + 16'(w));
    wr_reg(2, 16'h0000);
    for (int w = 0; w < 4; w++) mem_read(w, 16'h1000 + 16'(w));
    mem_read(2, 16'h0F05);
    // X wraps modulo 2^16
    wr_reg(2, 16'hFFFE);
    mem_write(1, 16'hBEEF);
    rd_reg(2, "R5 X wrapped to zero");
    wr_reg(2, 16'hFFFE);
    mem_read(0, 16'hBEEF);
    rd_reg(2, "R4 X wrapped to zero");

    // R8: resume
    do_exit(8'h08, lat, stray);
    check(go_pulse === 1'b1 && lat == EXIT_LEN, "R8 resume strobe timing", lat, EXIT_LEN);
    check(dbg_active === 1'b0, "R8 debug flag cleared", {31'd0, dbg_active}, 0);
    check(stray == 0, "R8 opcode ignored during exit", {31'd0, stray}, 0);
    @(negedge clk);
    check(go_pulse === 1'b0, "R8 strobe lasts one cycle", {31'd0, go_pulse}, 0);
    send_cmd(8'h63);
    check(rsp_valid === 1'b0, "R8 opcode ignored while running", {31'd0, rsp_valid}, 0);
    send_cmd(8'h43);
    send_data(16'hDEAD);
    return_dbg();
    check(dbg_active === 1'b1, "R8 debug re-entry", {31'd0, dbg_active}, 1);
    rd_all("R8 registers untouched while running");

    // R9: single step
    do_exit(8'h10, lat, stray);
    check(step_pulse === 1'b1 && lat == EXIT_LEN, "R9 step strobe timing", lat, EXIT_LEN);
    repeat (3) @(negedge clk);
    check(dbg_active === 1'b0 && step_pulse === 1'b0, "R9 waits for step completion",
          {30'd0, dbg_active, step_pulse}, 0);
    step_done = 1'b1;
    @(negedge clk);
    step_done = 1'b0;
    check(dbg_active === 1'b1, "R9 debug flag after step", {31'd0, dbg_active}, 1);
    rd_reg(0, "R9 reads work after step");

    // R10: tagged resume
    do_exit(8'h18, lat, stray);
    check(tag_pulse === 1'b1 && tag_en === 1'b1 && lat == EXIT_LEN,
          "R10 tagged resume", lat, EXIT_LEN);
    check(go_pulse === 1'b0 && step_pulse === 1'b0, "R12 single strobe",
          {30'd0, go_pulse, step_pulse}, 0);
    return_dbg();
    check(tag_en === 1'b0 && dbg_active === 1'b1, "R10 re-entry clears tagging",
          {30'd0, tag_en, dbg_active}, 1);

    done_flag = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule